// File: doc/BRIEF.md
# Interrupt Enable Gate and Reset Qualifier

This block holds the processor's interrupt enable bit and decides, cycle by cycle, whether a pending interrupt request is taken. A request is taken only when the enable bit is set, the bus is not held by another master, and the core is at an instruction boundary or halted. The cycle it is taken, an accept strobe tells the fetch logic to fetch a vectored instruction in place of the normal opcode. If the core was halted, a halt-exit strobe also goes out so that execution resumes. The enable bit is not cleared in the accept cycle. It is cleared at the first fetch-cycle T1 strobe after the accept. Until then, further acceptances are blocked.

The block also filters the external reset request. A request counts only after it has been seen high for a minimum number of consecutive clock edges. Once qualified, it drives a core-reset output, which asks for the program counter to be cleared to address 0 and the hold acknowledge to be cleared. It also clears the enable bit and any pending clear. Architectural registers and flags are outside this block and are not touched.

Top module: `intr_enable_ctrl`

## Requirements
- R1: With ei_i high, di_i low, core_reset_o low and no pending clear taking effect at a T1 strobe, inte_o is 1 after the next clock edge.
- R2: With di_i high, inte_o is 0 after the next clock edge. When ei_i and di_i are high in the same cycle, di_i wins.
- R3: int_accept_o is high in a cycle exactly when all of the following hold: int_req_i is high, inte_o is high, hold_i is low, core_reset_o is low, no clear is pending, and either instr_end_i or halted_i is high.
- R4: int_accept_o is never high in a cycle where hold_i is high.
- R5: After an accept cycle, inte_o stays as driven by ei_i/di_i until the first m1_t1_i strobe in a later cycle. After that edge, inte_o is 0, even if ei_i was high in the same cycle. A strobe in the accept cycle itself does not count.
- R6: From the edge after an accept until the edge where the pending clear takes effect, int_accept_o stays low.
- R7: halt_exit_o is high exactly in cycles where int_accept_o is high and halted_i is high.
- R8: core_reset_o goes high once reset_req_i has been sampled high on MIN_RESET_CYCLES (default 3) consecutive edges. It stays high until the edge that samples reset_req_i low. Shorter pulses leave core_reset_o, inte_o and acceptance unaffected.
- R9: While core_reset_o is high, the next edge clears inte_o and any pending clear, and int_accept_o stays low.
- R10: While rst_ni is low, inte_o, int_accept_o, halt_exit_o and core_reset_o are 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_req_i | input | 1 | Raw processor reset request, filtered for minimum length |
| int_req_i | input | 1 | Interrupt request line |
| ei_i | input | 1 | Enable-interrupt instruction strobe |
| di_i | input | 1 | Disable-interrupt instruction strobe |
| instr_end_i | input | 1 | Last cycle of the current instruction |
| halted_i | input | 1 | Core is in the halted state |
| hold_i | input | 1 | Bus is held by another master |
| m1_t1_i | input | 1 | T1 of an instruction-fetch machine cycle |
| inte_o | output | 1 | Interrupt enable bit |
| int_accept_o | output | 1 | Interrupt taken this cycle; fetch the vector instruction |
| halt_exit_o | output | 1 | Leave the halted state |
| core_reset_o | output | 1 | Qualified reset: clear program counter and hold acknowledge |

## Verification
The bench targets several corner cases:
- A T1 strobe in the accept cycle itself. A design that counted it would clear the enable one fetch early.
- An enable strobe on the clearing T1. A design with the wrong priority would leave interrupts enabled after taking one.
- Instruction ends between an accept and its T1. A design without the pending block would accept twice.
- A request raised during hold. A design without the hold gate would accept it.
- Reset pulses of one and two cycles. A design that did not qualify reset would wipe the enable bit.
- A three-cycle pulse, which must clear the enable bit.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned MIN_RESET_DEF = 3;

  typedef struct packed {
    logic req;
    logic instr_end;
    logic halted;
    logic hold;
  } accept_ctx_t;
endpackage

// File: rtl/intr_reset_qual.sv
module intr_reset_qual #(
  parameter int unsigned MIN_RESET = intr_pkg::MIN_RESET_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reset_req_i,
  output logic core_reset_o
);
  localparam int unsigned CNT_W = $clog2(MIN_RESET + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_RESET);

  logic [CNT_W-1:0] cnt_q;

  // saturating run-length counter on the raw request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!reset_req_i)     cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign core_reset_o = (cnt_q == CNT_MAX);

  a_r8_rise_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_reset_o) |-> $past(reset_req_i));
  a_r8_drop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reset_req_i |=> !core_reset_o);
endmodule

// File: rtl/intr_accept.sv
module intr_accept
  import intr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  accept_ctx_t ctx_i,
  input  logic        inte_i,
  input  logic        pend_i,
  input  logic        core_reset_i,
  output logic        accept_o,
  output logic        halt_exit_o
);
  logic boundary;

  assign boundary    = ctx_i.instr_end | ctx_i.halted;
  assign accept_o    = ctx_i.req & inte_i & ~pend_i & ~ctx_i.hold & boundary & ~core_reset_i;
  assign halt_exit_o = accept_o & ctx_i.halted;

  a_r3_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> inte_i && !core_reset_i);
  a_r4_no_accept_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctx_i.hold |-> !accept_o);
endmodule

// File: rtl/intr_enable_reg.sv
module intr_enable_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ei_i,
  input  logic di_i,
  input  logic m1_t1_i,
  input  logic accept_i,
  input  logic core_reset_i,
  output logic inte_o,
  output logic pend_o
);
  logic inte_q, pend_q, t1_clear;

  assign t1_clear = pend_q & m1_t1_i;

  // pending clear armed on accept, fires on the next fetch T1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pend_q <= 1'b0;
    else if (core_reset_i) pend_q <= 1'b0;
    else if (t1_clear)     pend_q <= 1'b0;
    else if (accept_i)     pend_q <= 1'b1;
  end

  // priority: reset, T1 clear, disable, enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           inte_q <= 1'b0;
    else if (core_reset_i) inte_q <= 1'b0;
    else if (t1_clear)     inte_q <= 1'b0;
    else if (di_i)         inte_q <= 1'b0;
    else if (ei_i)         inte_q <= 1'b1;
  end

  assign inte_o = inte_q;
  assign pend_o = pend_q;

  a_r1_enable_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ei_i && !di_i && !core_reset_i && !(pend_o && m1_t1_i) |=> inte_o);
  a_r2_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    di_i |=> !inte_o);
  a_r5_t1_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && m1_t1_i |=> !inte_o);
  a_r6_single_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o |-> !accept_i);
  a_r9_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_reset_i |=> !inte_o && !pend_o);
endmodule

// File: rtl/intr_enable_ctrl.sv
module intr_enable_ctrl
  import intr_pkg::*;
#(
  parameter int unsigned MIN_RESET_CYCLES = MIN_RESET_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reset_req_i,
  input  logic int_req_i,
  input  logic ei_i,
  input  logic di_i,
  input  logic instr_end_i,
  input  logic halted_i,
  input  logic hold_i,
  input  logic m1_t1_i,
  output logic inte_o,
  output logic int_accept_o,
  output logic halt_exit_o,
  output logic core_reset_o
);
  accept_ctx_t ctx;
  logic        core_reset, inte, pend, accept;

  assign ctx.req       = int_req_i;
  assign ctx.instr_end = instr_end_i;
  assign ctx.halted    = halted_i;
  assign ctx.hold      = hold_i;

  intr_reset_qual #(.MIN_RESET(MIN_RESET_CYCLES)) u_reset_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reset_req_i  (reset_req_i),
    .core_reset_o (core_reset)
  );

  intr_accept u_accept (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctx_i        (ctx),
    .inte_i       (inte),
    .pend_i       (pend),
    .core_reset_i (core_reset),
    .accept_o     (accept),
    .halt_exit_o  (halt_exit_o)
  );

  intr_enable_reg u_enable (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ei_i         (ei_i),
    .di_i         (di_i),
    .m1_t1_i      (m1_t1_i),
    .accept_i     (accept),
    .core_reset_i (core_reset),
    .inte_o       (inte),
    .pend_o       (pend)
  );

  assign inte_o       = inte;
  assign int_accept_o = accept;
  assign core_reset_o = core_reset;

  a_r7_halt_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_exit_o |-> halted_i && int_accept_o);
  a_r10_async_clear: assert property (@(posedge clk_i)
    !rst_ni |-> !inte_o && !core_reset_o && !int_accept_o);
endmodule

// File: tb/intr_enable_ctrl_bench.sv
module intr_enable_ctrl_bench;
  localparam int unsigned MINR = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reset_req = 0, int_req = 0, ei = 0, di = 0, iend = 0, halted = 0, hold = 0, m1 = 0;
  logic inte, acc, hexit, creset;

  int n_vec = 0, n_err = 0;
  bit done = 0;

  // model state
  int unsigned m_cnt = 0;
  logic m_inte = 0, m_pend = 0;

  always #2 clk = ~clk;

  intr_enable_ctrl #(.MIN_RESET_CYCLES(MINR)) u_intr_enable_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reset_req_i(reset_req), .int_req_i(int_req),
    .ei_i(ei), .di_i(di), .instr_end_i(iend), .halted_i(halted), .hold_i(hold),
    .m1_t1_i(m1), .inte_o(inte), .int_accept_o(acc), .halt_exit_o(hexit),
    .core_reset_o(creset)
  );

  function automatic logic f_core();
    return m_cnt == MINR;
  endfunction

  function automatic logic f_acc();
    return int_req & m_inte & ~m_pend & ~hold & (iend | halted) & ~f_core();
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    string t_acc, t_inte;
    t_acc  = hold ? "R4" : (m_pend ? "R6" : (f_core() ? "R9" : "R3"));
    t_inte = "R5";
    chk(t_acc, "int_accept_o", acc, f_acc());
    chk("R7", "halt_exit_o", hexit, f_acc() & halted);
    chk("R8", "core_reset_o", creset, f_core());
    chk(t_inte, "inte_o", inte, m_inte);
  endtask

  task automatic model_edge();
    logic core, a, t1c;
    core = f_core();
    a    = f_acc();
    t1c  = m_pend & m1;
    if (core) begin
      m_inte = 0; m_pend = 0;
    end else begin
      if (t1c) m_pend = 0; else if (a) m_pend = 1;
      if (t1c) m_inte = 0; else if (di) m_inte = 0; else if (ei) m_inte = 1;
    end
    if (!reset_req) m_cnt = 0; else if (m_cnt < MINR) m_cnt++;
  endtask

  task automatic step(input logic ir, input logic e, input logic d, input logic ie,
                      input logic ha, input logic ho, input logic t1, input logic rr);
    string tag;
    @(negedge clk);
    int_req = ir; ei = e; di = d; iend = ie; halted = ha; hold = ho; m1 = t1; reset_req = rr;
    #1;
    check_outputs();
    tag = f_core() ? "R9" : ((m_pend && t1) ? "R5" : (d ? "R2" : (e ? "R1" : "R5")));
    @(posedge clk);
    model_edge();
    #0.5;
    chk(tag, "inte_o after edge", inte, m_inte);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic hard_reset();
    @(negedge clk);
    #1;
    rst_ni = 0;
    int_req = 0; ei = 0; di = 0; iend = 0; halted = 0; hold = 0; m1 = 0; reset_req = 0;
    #0.5;
    chk("R10", "inte_o in reset", inte, 1'b0);
    chk("R10", "core_reset_o in reset", creset, 1'b0);
    chk("R10", "int_accept_o in reset", acc, 1'b0);
    m_cnt = 0; m_inte = 0; m_pend = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin
    #(150000 * 4);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    int unsigned rr_left;
    logic rr;
    void'($urandom(32'h5EED_0A11));
    hard_reset();
    idle(2);
    // R1 enable, then accept at instruction end with same-cycle T1 ignored (R5)
    step(0, 1, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 1, 0);
    // R6 second instruction end before T1 must not accept again
    step(1, 0, 0, 1, 0, 0, 0, 0);
    // R5 enable on the clearing T1 loses
    step(1, 1, 0, 0, 0, 0, 1, 0);
    step(1, 0, 0, 1, 0, 0, 0, 0);
    // R2 disable beats enable
    step(0, 1, 1, 0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0);
    // R4 hold blocks acceptance
    step(1, 0, 0, 1, 0, 1, 0, 0);
    step(1, 0, 0, 1, 1, 1, 0, 0);
    // R7 accept while halted
    step(1, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 0, 1, 0);
    // R8 short pulses ignored
    step(0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0);
    // R8/R9 qualified pulse clears enable, blocks accept
    step(0, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step(1, 1, 0, 1, 0, 0, 0, 1);
    idle(2);
    // R10 asynchronous reset mid-run
    step(0, 1, 0, 0, 0, 0, 0, 0);
    hard_reset();
    idle(1);

    rr_left = 0;
    for (int i = 0; i < 4000; i++) begin
      if (rr_left == 0 && ($urandom % 80) == 0) rr_left = 1 + $urandom % 5;
      rr = (rr_left > 0);
      if (rr_left > 0) rr_left--;
      step(($urandom % 3) != 0, ($urandom % 6) == 0, ($urandom % 12) == 0,
           ($urandom % 3) == 0, ($urandom % 5) == 0, ($urandom % 6) == 0,
           ($urandom % 4) == 0, rr);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule